// File: doc/BRIEF.md
# FizzBuzz Text Line Generator

This block supplies the character content of successive FizzBuzz lines. It runs through the numbers 1 to 100 and, for each one, gives a line of eight 4-bit character codes. The line reads "Fizz" for multiples of three, "Buzz" for multiples of five and "FizzBuzz" for multiples of both. Any other number appears in decimal. A display timing unit sends a one-cycle advance strobe each time a full character row has been drawn. The glyph renderer reads the packed line directly.

The block has no divider and no modulo operator. The number is kept as a chain of 4-bit BCD digit counters, with the ones digit carrying into the tens and the tens into the hundreds. Divisibility is tracked by two small cyclic counters, one modulo three and one modulo five, which step in lockstep with the number. After 100 the sequence starts again from 1.

Top module: `fizzline_gen`

## Requirements
- R1: After a synchronous active-low reset, the number is 1. `digits_o` reads 12'h001 and `line_o` reads 32'hFFFF_FFF1, which is the digit "1" followed by seven blanks.
- R2: A cycle with `adv_i` high moves the sequence forward by exactly one number, and the new line is visible from the next rising edge. A cycle with `adv_i` low leaves both outputs unchanged. Holding `adv_i` high for k cycles advances the sequence k times.
- R3: `digits_o` carries the number in BCD. The ones digit is in [3:0], the tens digit in [7:4] and the hundreds digit in [11:8], and each digit is always in the range 0 to 9.
- R4: A multiple of 3 that is not a multiple of 5 gives the characters F, i, z, z at positions 0 to 3, with blanks after them. The character codes are F=11, i=12 and z=14.
- R5: A multiple of 5 that is not a multiple of 3 gives B, u, z, z at positions 0 to 3, with blanks after them. The character codes are B=10 and u=13.
- R6: A multiple of 15 fills all eight positions with F, i, z, z, B, u, z, z.
- R7: Any other number is written in decimal with leading zeros suppressed. It is left-justified, so its first character sits at position 0, and the unused positions hold blank (code 15). Position p occupies bits [4p+3:4p] of `line_o`, and the digit codes are 0 to 9.
- R8: An advance taken while the number is 100 returns the sequence to 1. The second pass then repeats the first exactly, including the Fizz and Buzz placement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_i | input | 1 | Advance strobe, one number per high cycle |
| line_o | output | 32 | Eight packed 4-bit character codes, position 0 in [3:0] |
| digits_o | output | 12 | Current number as three BCD digits |

## Verification
The hardest case to reach from the ports is the wrap from 100 back to 1. At that point the two modulo counters must be reloaded rather than stepped, because 101 would otherwise leave them out of phase with the restarted number. The stimulus gets there by stepping through the whole sequence and comparing every line against a reference computed with ordinary arithmetic. It then takes two more steps, which exposes a mod-3 phase error as a missing "Fizz" on 3. A burst of back-to-back strobes checks that each high cycle counts once.

// File: rtl/fizzline_pkg.sv
// Shared character codes and helpers for the FizzBuzz line generator.
// Assumes a 16-entry glyph set, with digits on codes 0..9.
package fizzline_pkg;
    localparam int CHAR_W     = 4;
    localparam int LINE_CHARS = 8;
    localparam int LINE_W     = CHAR_W * LINE_CHARS;

    typedef logic [CHAR_W-1:0] glyph_t;

    localparam glyph_t GL_B     = 4'd10;
    localparam glyph_t GL_F     = 4'd11;
    localparam glyph_t GL_I     = 4'd12;
    localparam glyph_t GL_U     = 4'd13;
    localparam glyph_t GL_Z     = 4'd14;
    localparam glyph_t GL_BLANK = 4'd15;

    // Convert a small non-negative integer into up to eight packed BCD digits.
    function automatic logic [31:0] to_bcd(input int value);
        logic [31:0] r;
        int v;
        r = '0;
        v = value;
        for (int i = 0; i < 8; i++) begin
            r[i*4 +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction
endpackage

// File: rtl/mod_step_counter.sv
// Cyclic counter modulo MOD that steps with the number sequence.
// restart_i reloads the value 1, matching the number 1 that the sequence restarts on.
// Assumes MOD >= 2; zero_o flags divisibility of the current number.
module mod_step_counter #(
    parameter int MOD = 3,
    localparam int W  = (MOD > 2) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         restart_i,
    output logic [W-1:0] val_o,
    output logic         zero_o
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    // Residue register: reset and restart load 1, a step advances it cyclically.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            val_o <= W'(1);
        end else if (step_i) begin
            val_o <= (val_o == TOP) ? '0 : val_o + W'(1);
        end
    end

    assign zero_o = (val_o == '0);
endmodule

// File: rtl/bcd_chain.sv
// Chain of NDIG decimal digit counters, with the ones digit at the bottom.
// step_i adds one to the number; restart_i loads the value 1.
// Assumes step_i and restart_i are never high together.
module bcd_chain #(
    parameter int NDIG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              restart_i,
    output logic [NDIG*4-1:0] digits_o
);
    logic [NDIG:0] carry;

    assign carry[0] = step_i;

    for (genvar d = 0; d < NDIG; d++) begin : g_dig
        localparam logic [3:0] LOAD = (d == 0) ? 4'd1 : 4'd0;
        logic [3:0] val;

        // One decimal digit: it advances on an incoming carry and wraps 9 to 0.
        always_ff @(posedge clk) begin
            if (!rst_n || restart_i) begin
                val <= LOAD;
            end else if (carry[d]) begin
                val <= (val == 4'd9) ? 4'd0 : val + 4'd1;
            end
        end

        assign carry[d+1]       = carry[d] && (val == 4'd9);
        assign digits_o[d*4 +: 4] = val;
    end
endmodule

// File: rtl/line_composer.sv
// Builds the eight-character line from the BCD number and the divisibility flags.
// Purely combinational. Positions are numbered from 0, and position p sits at bits [4p+3:4p].
// Assumes NDIG <= LINE_CHARS.
module line_composer
    import fizzline_pkg::*;
#(
    parameter int NDIG = 3
) (
    input  logic [NDIG*4-1:0] digits_i,
    input  logic              fizz_i,
    input  logic              buzz_i,
    output logic [LINE_W-1:0] line_o
);
    localparam int KW = $clog2(LINE_CHARS);

    glyph_t ch [LINE_CHARS];

    // Choose a word or the left-justified decimal number with leading zeros suppressed.
    always_comb begin : pick
        logic [KW-1:0] k;
        logic          lead;
        k    = '0;
        lead = 1'b0;
        for (int i = 0; i < LINE_CHARS; i++) ch[i] = GL_BLANK;
        if (fizz_i || buzz_i) begin
            if (fizz_i) begin
                ch[0] = GL_F; ch[1] = GL_I; ch[2] = GL_Z; ch[3] = GL_Z;
            end
            if (buzz_i) begin
                ch[fizz_i ? 4 : 0] = GL_B;
                ch[fizz_i ? 5 : 1] = GL_U;
                ch[fizz_i ? 6 : 2] = GL_Z;
                ch[fizz_i ? 7 : 3] = GL_Z;
            end
        end else begin
            for (int d = NDIG - 1; d >= 0; d--) begin
                if (lead || (digits_i[d*4 +: 4] != 4'd0) || (d == 0)) begin
                    ch[k] = digits_i[d*4 +: 4];
                    k     = k + 1'b1;
                    lead  = 1'b1;
                end
            end
        end
    end

    // Pack the character positions into the flat line vector.
    always_comb begin
        for (int i = 0; i < LINE_CHARS; i++) line_o[i*CHAR_W +: CHAR_W] = ch[i];
    end
endmodule

// File: rtl/fizzline_gen.sv
// FizzBuzz text line generator: one number per advance strobe, from 1 up to SEQ_LAST, then back to 1.
// It uses BCD digit counters and mod-3/mod-5 residue counters, so no divider is needed.
// Assumes adv_i is synchronous to clk; the outputs change on the edge that samples adv_i high.
module fizzline_gen
    import fizzline_pkg::*;
#(
    parameter int NDIG     = 3,
    parameter int SEQ_LAST = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    output logic [LINE_W-1:0] line_o,
    output logic [NDIG*4-1:0] digits_o
);
    localparam logic [31:0]       LAST_ALL = to_bcd(SEQ_LAST);
    localparam logic [NDIG*4-1:0] LAST_BCD = LAST_ALL[NDIG*4-1:0];

    logic at_last;
    logic step;
    logic restart;
    logic fizz;
    logic buzz;
    logic [1:0] m3_val;
    logic [2:0] m5_val;

    // Sequence control: step normally, or restart when the last number is on show.
    always_comb begin
        at_last = (digits_o == LAST_BCD);
        step    = adv_i && !at_last;
        restart = adv_i && at_last;
    end

    bcd_chain #(.NDIG(NDIG)) u_num (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .digits_o  (digits_o)
    );

    mod_step_counter #(.MOD(3)) u_m3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .val_o     (m3_val),
        .zero_o    (fizz)
    );

    mod_step_counter #(.MOD(5)) u_m5 (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .restart_i (restart),
        .val_o     (m5_val),
        .zero_o    (buzz)
    );

    line_composer #(.NDIG(NDIG)) u_comp (
        .digits_i (digits_o),
        .fizz_i   (fizz),
        .buzz_i   (buzz),
        .line_o   (line_o)
    );
endmodule

// File: rtl/fizzline_chk.sv
// Checker for fizzline_gen, bound to every instance of it.
// It observes the ports only.
module fizzline_chk
    import fizzline_pkg::*;
#(
    parameter int NDIG     = 3,
    parameter int SEQ_LAST = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_i,
    input logic [LINE_W-1:0] line_o,
    input logic [NDIG*4-1:0] digits_o
);
    localparam logic [31:0]       LAST_ALL = to_bcd(SEQ_LAST);
    localparam logic [NDIG*4-1:0] LAST_BCD = LAST_ALL[NDIG*4-1:0];
    localparam logic [NDIG*4-1:0] ONE_BCD  = {{(NDIG*4-1){1'b0}}, 1'b1};

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> ($stable(line_o) && $stable(digits_o)));  // R2

    AST_ONES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && digits_o[3:0] != 4'd9 && digits_o != LAST_BCD)
        |=> (digits_o[3:0] == $past(digits_o[3:0]) + 4'd1));  // R2

    for (genvar d = 0; d < NDIG; d++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            digits_o[d*4 +: 4] <= 4'd9);  // R3
    end

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        digits_o != '0);  // R1

    AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && digits_o == LAST_BCD) |=> (digits_o == ONE_BCD));  // R8

    AST_FIRST_NOT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        line_o[3:0] != GL_BLANK);  // R7
endmodule

bind fizzline_gen fizzline_chk #(.NDIG(NDIG), .SEQ_LAST(SEQ_LAST)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv_i),
    .line_o   (line_o),
    .digits_o (digits_o)
);

// File: tb/sim_fizzline_gen.sv
// Directed bench for fizzline_gen. Each task drives one scenario and checks its own results.
module sim_fizzline_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv = 1'b0;
    logic [31:0] line;
    logic [11:0] digits;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fizzline_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (adv),
        .line_o   (line),
        .digits_o (digits)
    );

    // Reference line, computed from the requirements with ordinary arithmetic.
    function automatic logic [31:0] exp_line(input int n);
        logic [3:0] c [8];
        logic [31:0] r;
        for (int i = 0; i < 8; i++) c[i] = 4'd15;
        if (n % 15 == 0) begin
            c[0]=4'd11; c[1]=4'd12; c[2]=4'd14; c[3]=4'd14;
            c[4]=4'd10; c[5]=4'd13; c[6]=4'd14; c[7]=4'd14;
        end else if (n % 3 == 0) begin
            c[0]=4'd11; c[1]=4'd12; c[2]=4'd14; c[3]=4'd14;
        end else if (n % 5 == 0) begin
            c[0]=4'd10; c[1]=4'd13; c[2]=4'd14; c[3]=4'd14;
        end else if (n >= 100) begin
            c[0]=4'(n/100); c[1]=4'((n/10)%10); c[2]=4'(n%10);
        end else if (n >= 10) begin
            c[0]=4'(n/10); c[1]=4'(n%10);
        end else begin
            c[0]=4'(n);
        end
        for (int i = 0; i < 8; i++) r[i*4 +: 4] = c[i];
        return r;
    endfunction

    function automatic logic [11:0] exp_digits(input int n);
        return {4'(n/100), 4'((n/10)%10), 4'(n%10)};
    endfunction

    function automatic string kind_tag(input int n);
        if (n % 15 == 0) return "R6";
        if (n % 3 == 0)  return "R4";
        if (n % 5 == 0)  return "R5";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        @(negedge clk) adv = 1'b1;
        @(negedge clk) adv = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: the reset state shows the number 1.
    task automatic t_reset();
        do_reset();
        check("R1 line", line, 32'hFFFF_FFF1);
        check("R1 digits", {20'd0, digits}, 32'h001);
    endtask

    // R2: idle cycles change nothing.
    task automatic t_hold(input int n);
        repeat (5) @(negedge clk);
        check("R2 idle line", line, exp_line(n));
        check("R2 idle digits", {20'd0, digits}, {20'd0, exp_digits(n)});
    endtask

    // R3-R7: step through the whole sequence, checking every line.
    task automatic t_sweep();
        for (int n = 2; n <= 100; n++) begin
            pulse();
            check(kind_tag(n), line, exp_line(n));
            check("R3 digits", {20'd0, digits}, {20'd0, exp_digits(n)});
        end
    endtask

    // R8: wrap from 100 back to 1, with the residues restarted.
    task automatic t_wrap();
        pulse();
        check("R8 wrap line", line, exp_line(1));
        check("R8 wrap digits", {20'd0, digits}, 32'h001);
        pulse();
        check("R8 second pass 2", line, exp_line(2));
        pulse();
        check("R8 second pass 3", line, exp_line(3));
    endtask

    // R2: a held strobe advances once per cycle.
    task automatic t_burst();
        @(negedge clk) adv = 1'b1;
        repeat (3) @(negedge clk);
        adv = 1'b0;
        check("R2 burst line", line, exp_line(6));
        check("R2 burst digits", {20'd0, digits}, {20'd0, exp_digits(6)});
        t_hold(6);
    endtask

    // R1: a reset in mid-sequence returns to 1.
    task automatic t_mid_reset();
        pulse();
        do_reset();
        check("R1 mid reset line", line, exp_line(1));
        pulse(); pulse();
        check("R1 after mid reset", line, exp_line(3));
    endtask

    initial begin
        t_reset();
        t_hold(1);
        t_sweep();
        t_hold(100);
        t_wrap();
        t_burst();
        t_mid_reset();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule